// File: doc/BRIEF.md
# Multi-channel ADC threshold monitor

This block watches a stream of ADC conversion results on behalf of eight monitoring channels. Each sample arrives with the number of the ADC input it came from. Each channel is bound to one ADC input and holds an unsigned 16-bit low limit and high limit. When a channel is measuring and a sample for its input is compared, a result at or below the low limit latches the channel's bit in the low status byte. A result at or above the high limit latches its bit in the high status byte. Status bits stay set until software writes 1 to them. A level interrupt is raised while any latched bit also has its interrupt enable set.

Samples enter on a valid/ready port. `smp_ready` is high only while the monitor is running. Running starts when a conversion request is written while the global enable is set, and stops when the global enable is cleared. While `smp_ready` is low, a presented sample is held back and is never compared. A sample is taken in each cycle where both `smp_valid` and `smp_ready` are high.

Each channel picks one of three shared interval timers, or no timer. A channel on a timer compares only the first sample for its input after that timer ticks. A channel with no timer compares every sample. Configuration and status sit behind a byte-wide register port. Writes take effect on the clock edge. Read data is combinational from the address.

Top module: `adc_thr_mon`

## Requirements
- R1: After reset, every register reads 0 except the channel-count register, and `irq` and `smp_ready` are low.
- R2: Channel n has an 8-byte window at 0x60+8n. The bytes are, by offset:
  - 0: ADC input select.
  - 1 and 2: low limit, low byte first.
  - 3 and 4: high limit, low byte first.
  - 5: timer select, in bits 1:0.
  - 6: control, with a settle-delay code in bits 3:0 and a calibration select in bits 5:4.
  - 7: enable byte, with bit 7 for measure, bit 1 for high interrupt enable and bit 0 for low interrupt enable.
  Unimplemented bits read 0.
- R3: Bit 7 at 0x46 is the global enable. Writing bit 7 at 0x47 while that enable is set starts running, and 0x47 bit 7 reads back the running state. `smp_ready` is high exactly while running. Clearing the global enable stops running.
- R4: A compared sample sets low status bit n when code <= low limit and high status bit n when code >= high limit, both compared unsigned. A sample is compared only for channels that are measuring and whose input select equals `smp_input`. Several channels may share one input.
- R5: Low status sits at 0x0a and high status at 0x0b, with bit n for channel n. Bits are sticky, writing 1 clears a bit, and writing 0 has no effect. A set and a clear of the same bit in the same cycle leave the bit set.
- R6: Writing the enable byte with bit 7 = 0 clears both status bits of that channel in the same cycle.
- R7: `irq` is the OR over channels of (low status AND low interrupt enable) OR (high status AND high interrupt enable), gated by measure enable.
- R8: Timer select 3 compares every sample. Selects 0, 1 and 2 use shared timers with periods P0, P1 and P2 clock cycles. A channel on a timer compares only its first matching sample after a tick of that timer.
- R9: 0x0f reads the channel count (8) and ignores writes. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample accepted when high with smp_valid |
| smp_input | input | 8 | ADC input number of the sample |
| smp_code | input | 16 | Conversion result, unsigned |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps every channel across codes on both sides of each limit (one below, equal, one above) and at both ends of the range. A design with an off-by-one or a signed compare would latch the wrong status bit or miss one at the equal point. It probes the clash of a sample-set and a write-1-clear in one cycle, which a design with the wrong priority would lose, and the shared-input and wrong-input cases, where a bad input decode would leak status to other channels. It also checks that a channel on an interval timer ignores a second violating sample before the next tick; a design that compares freely would flag it at once.

// File: rtl/adc_thr_pkg.sv
package adc_thr_pkg;
  localparam logic [7:0] A_STAT_LO = 8'h0a;
  localparam logic [7:0] A_STAT_HI = 8'h0b;
  localparam logic [7:0] A_NCH     = 8'h0f;
  localparam logic [7:0] A_GEN     = 8'h46;
  localparam logic [7:0] A_CONV    = 8'h47;
  localparam logic [7:0] A_CH_BASE = 8'h60;
  localparam logic [1:0] TSEL_NONE = 2'd3;
  localparam int         THR_W     = 16;

  typedef struct packed {
    logic [7:0]       sel;
    logic [THR_W-1:0] lo;
    logic [THR_W-1:0] hi;
    logic [1:0]       tsel;
    logic [5:0]       ctl;
    logic             meas;
    logic             ie_hi;
    logic             ie_lo;
  } chan_cfg_t;
endpackage

// File: rtl/adc_thr_cfg.sv
module adc_thr_cfg
  import adc_thr_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      addr,
  input  logic [7:0]      wdata,
  output chan_cfg_t       cfg [NCH],
  output logic            gen_en,
  output logic            run,
  output logic [NCH-1:0]  dis,
  output logic [7:0]      rdata
);
  localparam logic [4:0] WIN0 = A_CH_BASE[7:3];

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    chan_cfg_t r;
    logic      hit;
    assign hit    = wr_en && (addr[7:3] == WIN0 + 5'(n));
    assign dis[n] = hit && (addr[2:0] == 3'd7) && !wdata[7];
    assign cfg[n] = r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r <= '0;
      end else if (hit) begin
        case (addr[2:0])
          3'd0: r.sel      <= wdata;
          3'd1: r.lo[7:0]  <= wdata;
          3'd2: r.lo[15:8] <= wdata;
          3'd3: r.hi[7:0]  <= wdata;
          3'd4: r.hi[15:8] <= wdata;
          3'd5: r.tsel     <= wdata[1:0];
          3'd6: r.ctl      <= wdata[5:0];
          default: begin
            r.meas  <= wdata[7];
            r.ie_hi <= wdata[1];
            r.ie_lo <= wdata[0];
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_en <= 1'b0;
      run    <= 1'b0;
    end else if (wr_en && addr == A_GEN) begin
      gen_en <= wdata[7];
      if (!wdata[7]) run <= 1'b0;
    end else if (wr_en && addr == A_CONV && wdata[7] && gen_en) begin
      run <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_GEN:  rdata = {gen_en, 7'b0};
      A_CONV: rdata = {run, 7'b0};
      A_NCH:  rdata = 8'(NCH);
      default: begin
        for (int n = 0; n < NCH; n++) begin
          if (addr[7:3] == WIN0 + 5'(n)) begin
            case (addr[2:0])
              3'd0: rdata = cfg[n].sel;
              3'd1: rdata = cfg[n].lo[7:0];
              3'd2: rdata = cfg[n].lo[15:8];
              3'd3: rdata = cfg[n].hi[7:0];
              3'd4: rdata = cfg[n].hi[15:8];
              3'd5: rdata = {6'b0, cfg[n].tsel};
              3'd6: rdata = {2'b0, cfg[n].ctl};
              default: rdata = {cfg[n].meas, 5'b0, cfg[n].ie_hi, cfg[n].ie_lo};
            endcase
          end
        end
      end
    endcase
  end

  p_run_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> gen_en);
endmodule

// File: rtl/adc_thr_ticks.sv
module adc_thr_ticks #(
  parameter int P0 = 16,
  parameter int P1 = 32,
  parameter int P2 = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  output logic [2:0] tick
);
  localparam int PMAX = (P0 > P1) ? ((P0 > P2) ? P0 : P2) : ((P1 > P2) ? P1 : P2);
  localparam int CW   = $clog2(PMAX + 1);
  localparam int PERS [3] = '{P0, P1, P2};

  for (genvar k = 0; k < 3; k++) begin : g_tmr
    localparam logic [CW-1:0] LAST = CW'(PERS[k] - 1);
    logic [CW-1:0] cnt;
    assign tick[k] = run && (cnt == LAST);

    always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else cnt <= cnt + 1'b1;
    end

    p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
  end
endmodule

// File: rtl/adc_thr_status.sv
module adc_thr_status
  import adc_thr_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chan_cfg_t        cfg [NCH],
  input  logic [NCH-1:0]   dis,
  input  logic [2:0]       tick,
  input  logic             smp_fire,
  input  logic [7:0]       smp_input,
  input  logic [THR_W-1:0] smp_code,
  input  logic [NCH-1:0]   w1c_lo,
  input  logic [NCH-1:0]   w1c_hi,
  output logic [NCH-1:0]   stat_lo,
  output logic [NCH-1:0]   stat_hi,
  output logic             irq
);
  logic [NCH-1:0] qual;
  logic [3:0]     tick4;
  assign tick4 = {1'b0, tick};

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic armed, take, lo_set, hi_set, tmr_free;
    logic unused_ctl;
    assign unused_ctl = ^cfg[n].ctl;
    assign tmr_free   = (cfg[n].tsel == TSEL_NONE);
    assign take   = smp_fire && cfg[n].meas && (cfg[n].sel == smp_input) && (tmr_free || armed);
    assign lo_set = take && (smp_code <= cfg[n].lo);
    assign hi_set = take && (smp_code >= cfg[n].hi);

    always_ff @(posedge clk) begin
      if (!rst_n || dis[n]) armed <= 1'b0;
      else if (!tmr_free && tick4[cfg[n].tsel]) armed <= 1'b1;
      else if (take) armed <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || dis[n]) begin
        stat_lo[n] <= 1'b0;
        stat_hi[n] <= 1'b0;
      end else begin
        if (lo_set) stat_lo[n] <= 1'b1;
        else if (w1c_lo[n]) stat_lo[n] <= 1'b0;
        if (hi_set) stat_hi[n] <= 1'b1;
        else if (w1c_hi[n]) stat_hi[n] <= 1'b0;
      end
    end

    assign qual[n] = cfg[n].meas && ((stat_lo[n] && cfg[n].ie_lo) || (stat_hi[n] && cfg[n].ie_hi));
  end

  assign irq = |qual;

  logic [NCH-1:0] meas_v;
  always_comb for (int n = 0; n < NCH; n++) meas_v[n] = cfg[n].meas;

  p_stat_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_lo | stat_hi) & ~meas_v) == '0);
  p_rise_needs_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_fire) |-> (((stat_lo & ~$past(stat_lo)) | (stat_hi & ~$past(stat_hi))) == '0));
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(w1c_lo) == '0 && $past(w1c_hi) == '0 && $past(dis) == '0)
      |-> ((($past(stat_lo) & ~stat_lo) | ($past(stat_hi) & ~stat_hi)) == '0));
endmodule

// File: rtl/adc_thr_mon.sv
module adc_thr_mon
  import adc_thr_pkg::*;
#(
  parameter int NCH = 8,
  parameter int P0  = 16,
  parameter int P1  = 32,
  parameter int P2  = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        smp_valid,
  output logic        smp_ready,
  input  logic [7:0]  smp_input,
  input  logic [15:0] smp_code,
  output logic        irq
);
  chan_cfg_t      cfg [NCH];
  logic           gen_en, run;
  logic [NCH-1:0] dis, stat_lo, stat_hi, w1c_lo, w1c_hi;
  logic [7:0]     cfg_rdata;
  logic [2:0]     tick;
  logic           smp_fire;

  assign smp_ready = run;
  assign smp_fire  = smp_valid && smp_ready;
  assign w1c_lo = (reg_wr && reg_addr == A_STAT_LO) ? reg_wdata[NCH-1:0] : '0;
  assign w1c_hi = (reg_wr && reg_addr == A_STAT_HI) ? reg_wdata[NCH-1:0] : '0;

  adc_thr_cfg #(.NCH(NCH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cfg(cfg), .gen_en(gen_en), .run(run), .dis(dis), .rdata(cfg_rdata)
  );

  adc_thr_ticks #(.P0(P0), .P1(P1), .P2(P2)) u_ticks (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  adc_thr_status #(.NCH(NCH)) u_stat (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .dis(dis), .tick(tick),
    .smp_fire(smp_fire), .smp_input(smp_input), .smp_code(smp_code),
    .w1c_lo(w1c_lo), .w1c_hi(w1c_hi),
    .stat_lo(stat_lo), .stat_hi(stat_hi), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      A_STAT_LO: reg_rdata = 8'(stat_lo);
      A_STAT_HI: reg_rdata = 8'(stat_hi);
      default:   reg_rdata = cfg_rdata;
    endcase
  end

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((stat_lo | stat_hi) != '0));
  p_ready_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |-> gen_en);
endmodule

// File: tb/sim_adc_thr_mon.sv
`timescale 1ns/1ps
module sim_adc_thr_mon;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        smp_valid = 0;
  logic        smp_ready;
  logic [7:0]  smp_input = 0;
  logic [15:0] smp_code = 0;
  logic        irq;

  int nvec = 0;
  int nbad = 0;
  int cyc = 0;
  int start = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_thr_mon u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_input(smp_input), .smp_code(smp_code), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic send(input logic [7:0] ch, input logic [15:0] code);
    @(negedge clk);
    smp_valid = 1; smp_input = ch; smp_code = code;
    @(posedge clk);
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic prog(input int n, input logic [7:0] sel, input logic [15:0] lo,
                      input logic [15:0] hi, input logic [7:0] ts, input logic [7:0] en);
    logic [7:0] b;
    b = 8'h60 + 8'(8*n);
    wr(b, sel); wr(b+1, lo[7:0]); wr(b+2, lo[15:8]);
    wr(b+3, hi[7:0]); wr(b+4, hi[15:8]); wr(b+5, ts); wr(b+7, en);
  endtask

  function automatic logic [15:0] lo_of(input int n); return 16'h1000 + 16'(n * 16'h100); endfunction
  function automatic logic [15:0] hi_of(input int n); return 16'h8000 + 16'(n * 16'h100); endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, dl, dh;
    logic [15:0] codes [8];
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    rd(8'h0a, d); chk("R1 stat_lo", d, 0);
    rd(8'h0b, d); chk("R1 stat_hi", d, 0);
    rd(8'h46, d); chk("R1 gen", d, 0);
    rd(8'h47, d); chk("R1 conv", d, 0);
    rd(8'h67, d); chk("R1 ch0 en", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ready", smp_ready, 0);

    // R9 count register and unmapped
    rd(8'h0f, d); chk("R9 count", d, 8);
    wr(8'h0f, 8'h55); rd(8'h0f, d); chk("R9 count ro", d, 8);
    wr(8'h20, 8'hff); rd(8'h20, d); chk("R9 unmapped", d, 0);

    // R2 window layout
    for (int k = 0; k < 8; k++) wr(8'h78 + 8'(k), 8'hff);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] e;
      e = (k == 5) ? 8'h03 : (k == 6) ? 8'h3f : (k == 7) ? 8'h83 : 8'hff;
      rd(8'h78 + 8'(k), d); chk("R2 ch3 byte", d, e);
    end
    wr(8'h76, 8'ha5); rd(8'h76, d); chk("R2 ch2 ctl", d, 8'h25);
    wr(8'h9a, 8'h3c); rd(8'h9a, d); chk("R2 ch7 lo msb", d, 8'h3c);
    rd(8'h7a, d); chk("R2 ch3 neighbour", d, 8'hff);

    // R3 conversion request ignored while disabled
    wr(8'h47, 8'h80);
    rd(8'h47, d); chk("R3 conv no enable", d, 0);
    chk("R3 ready off", smp_ready, 0);
    wr(8'h46, 8'h80); wr(8'h47, 8'h80); start = cyc;
    rd(8'h47, d); chk("R3 running", d, 8'h80);
    chk("R3 ready on", smp_ready, 1);

    // R4 sweep every channel across limit boundaries
    for (int n = 0; n < 8; n++) prog(n, 8'h10 + 8'(n), lo_of(n), hi_of(n), 8'h03, 8'h83);
    for (int n = 0; n < 8; n++) begin
      codes[0] = 16'h0000; codes[1] = lo_of(n) - 1; codes[2] = lo_of(n); codes[3] = lo_of(n) + 1;
      codes[4] = hi_of(n) - 1; codes[5] = hi_of(n); codes[6] = hi_of(n) + 1; codes[7] = 16'hffff;
      for (int c = 0; c < 8; c++) begin
        logic el, eh;
        wr(8'h0a, 8'hff); wr(8'h0b, 8'hff);
        send(8'h10 + 8'(n), codes[c]);
        el = (codes[c] <= lo_of(n));
        eh = (codes[c] >= hi_of(n));
        rd(8'h0a, dl); chk("R4 low bit", dl, 8'(el) << n);
        rd(8'h0b, dh); chk("R4 high bit", dh, 8'(eh) << n);
        chk("R7 irq sweep", irq, el | eh);
      end
    end
    wr(8'h0a, 8'hff); wr(8'h0b, 8'hff);
    send(8'h77, 16'h0000);
    rd(8'h0a, d); chk("R4 wrong input", d, 0);
    // R4 measure disabled: no compare
    wr(8'h8f, 8'h03); send(8'h15, 16'h0000);
    rd(8'h0a, d); chk("R4 meas off", d, 0);
    wr(8'h8f, 8'h83);
    // R4 shared input
    wr(8'h90, 8'h17); send(8'h17, 16'h0000);
    rd(8'h0a, d); chk("R4 shared input", d, 8'hc0);
    wr(8'h0a, 8'hff); wr(8'h90, 8'h16);

    // R5 set wins over clear; write of 0 is ignored
    @(negedge clk);
    smp_valid = 1; smp_input = 8'h12; smp_code = 16'h0000;
    reg_wr = 1; reg_addr = 8'h0a; reg_wdata = 8'h04;
    @(posedge clk); @(negedge clk);
    smp_valid = 0; reg_wr = 0;
    rd(8'h0a, d); chk("R5 set wins", d, 8'h04);
    wr(8'h0a, 8'h00); rd(8'h0a, d); chk("R5 zero write", d, 8'h04);
    wr(8'h0a, 8'h04); rd(8'h0a, d); chk("R5 w1c", d, 8'h00);

    // R6 measure disable clears status
    send(8'h13, 16'hffff); send(8'h13, 16'h0000);
    rd(8'h0b, d); chk("R6 pre hi", d, 8'h08);
    wr(8'h7f, 8'h03);
    rd(8'h0a, d); chk("R6 lo cleared", d, 0);
    rd(8'h0b, d); chk("R6 hi cleared", d, 0);
    chk("R6 irq", irq, 0);

    // R7 interrupt enables qualify status
    wr(8'h67, 8'h81);
    send(8'h10, 16'hffff);
    rd(8'h0b, d); chk("R7 hi latched", d, 8'h01);
    chk("R7 irq masked", irq, 0);
    send(8'h10, 16'h0000);
    chk("R7 irq low", irq, 1);
    wr(8'h0a, 8'h01); chk("R7 irq after clear", irq, 0);
    wr(8'h0b, 8'h01);

    // R8 timer 2 channel compares once per tick
    wr(8'h6d, 8'h02);
    while (!(((cyc - start) % 64) == 20)) @(negedge clk);
    send(8'h11, 16'h0000);
    rd(8'h0a, d); chk("R8 first after tick", d, 8'h02);
    wr(8'h0a, 8'h02);
    send(8'h11, 16'h0000);
    rd(8'h0a, d); chk("R8 no rearm", d, 8'h00);
    while (!(((cyc - start) % 64) == 20)) @(negedge clk);
    send(8'h11, 16'h0000);
    rd(8'h0a, d); chk("R8 next tick", d, 8'h02);

    // R3 stop
    wr(8'h46, 8'h00);
    rd(8'h47, d); chk("R3 stopped", d, 0);
    chk("R3 ready off again", smp_ready, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule